// File: doc/BRIEF.md
# Triggered ADC Command Queue Sequencer

This block feeds one ADC conversion engine from two command queues. The primary queue is an eight-entry command list that software writes once. A periodic timebase trigger replays it. Pause and loop-start flags in the command words turn the list into a loop: each trigger runs the list from the loop start up to the next paused command, and after a fixed settling overhead the queue waits for the next trigger. The secondary queue is an eight-entry FIFO of streaming commands. It may use the converter only while the primary queue is idle and waiting.

Each 32-bit command word is decoded into a channel, a sample-time code and a result tag. A conversion counter times each conversion in ADC clocks, where one clock edge is one ADC clock. A dummy result built from the channel and a running conversion count stands in for the analog converter. A trigger that arrives before the primary queue can accept it sets a sticky overflow flag. A secondary conversion may delay the start of a primary run. That delay is then paid back out of the spare clocks of the following trigger periods without flagging an overflow. As a result, a small per-period surplus builds up until one whole secondary conversion fits.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: Command bits are numbered with 0 as the LSB. Bit 30 is pause, bit 29 is loop start, [23:20] is the result tag, [19:18] is the sample-time code and [15:8] is the channel. All other bits have no effect on timing or results. The secondary queue ignores pause and loop start.
- R2: A conversion lasts a base time plus a sample time. The base time is 13 clocks for channels 96 to 127 and 14 clocks for any other channel. The sample time is 2, 8, 64 or 128 clocks for codes 0, 1, 2 and 3. Results of back-to-back conversions are spaced by exactly the later command's time.
- R3: Each result has res_data = {channel, n} and res_tag equal to the command's tag, where n is the 8-bit count of conversions completed since reset, starting at 0.
- R4: While trig_en is high, a trigger fires every trig_period+1 clocks. A triggered primary queue issues its commands back to back.
- R5: A primary command with the loop-start flag records its entry as the loop start (entry 0 until one is seen). After a command with the pause flag is issued, the pointer returns to the loop start and the queue waits for a trigger.
- R6: The primary queue becomes ready for a trigger 14 clocks after its paused command completes. A period equal to the run time plus 14 never overflows; a period one clock shorter does.
- R7: A trigger sets the overflow flag when a trigger is already pending, or when the primary queue is not waiting and its current run began on time.
- R8: ovf_flag stays set until ovf_clr is 1 in a cycle with no new overflow.
- R9: A secondary command is issued, in write order, only when the converter is free, the primary queue is waiting, and no trigger is present or pending. It is never issued during the overhead.
- R10: A trigger that is delayed by a secondary conversion is held pending, and the late run that follows tolerates the next trigger. With a 121-clock run and 16-clock secondary commands, periods of 151, 143 and 136 clocks give one secondary result every 1, 2 and 16 primary runs respectively, with no overflow.
- R11: A result stays valid and unchanged until res_ready. The next conversion does not complete while the result is held.
- R12: A synchronous reset clears the queue pointers, the loop start, the pending trigger, the overflow flag, the result valid and the conversion count. The contents of the primary queue are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst | input | 1 | Synchronous active-high reset |
| pq_we | input | 1 | Primary queue entry write strobe |
| pq_waddr | input | 3 | Primary queue entry index |
| pq_wdata | input | 32 | Primary command word |
| sq_we | input | 1 | Secondary FIFO push (dropped when full) |
| sq_wdata | input | 32 | Secondary command word |
| trig_en | input | 1 | Enables the periodic trigger |
| trig_period | input | 16 | Trigger period in clocks, minus one |
| ovf_clr | input | 1 | Write 1 to clear the overflow flag |
| ovf_flag | output | 1 | Sticky trigger-overflow flag |
| res_valid | output | 1 | Result available |
| res_data | output | 16 | Dummy result {channel, conversion count} |
| res_tag | output | 4 | Tag of the command that produced the result |
| res_ready | input | 1 | Result accepted |

## Verification
The bound checker checks the following on every cycle:
- the stickiness of the overflow flag and that it can only rise while triggering is enabled;
- that a stalled result holds its value;
- that the two queues never issue in the same cycle;
- that every issue loads at least the minimum conversion time;
- the state right after reset.

Only the directed scenarios can show the rest:
- exact conversion times;
- the loop-start and pause replay order;
- the 14-clock overhead boundary between a clean period and an overflowing one;
- the slow buildup of spare clocks that lets one secondary conversion through every 1, 2 or 16 runs.

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer #(
  parameter int QDEPTH    = 8,
  parameter int PER_W     = 16,
  parameter int OVH_CLKS  = 14,
  parameter int DIFF_BASE = 13,
  parameter int SE_BASE   = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pq_we,
  input  logic [$clog2(QDEPTH)-1:0]  pq_waddr,
  input  logic [31:0]                pq_wdata,
  input  logic                       sq_we,
  input  logic [31:0]                sq_wdata,
  input  logic                       trig_en,
  input  logic [PER_W-1:0]           trig_period,
  input  logic                       ovf_clr,
  output logic                       ovf_flag,
  output logic                       res_valid,
  output logic [15:0]                res_data,
  output logic [3:0]                 res_tag,
  input  logic                       res_ready
);
  localparam int AW = $clog2(QDEPTH);
  localparam int CW = $clog2(SE_BASE + 128 + 1);
  localparam int OW = $clog2(SE_BASE + 128 + OVH_CLKS + 1);

  typedef enum logic [1:0] {P_WAIT, P_RUN, P_OVH} pst_t;

  function automatic logic [CW-1:0] conv_len(input logic [13:0] f);
    int b, s;
    b = (f[7:5] == 3'b011) ? DIFF_BASE : SE_BASE;
    case (f[9:8])
      2'd0: s = 2;
      2'd1: s = 8;
      2'd2: s = 64;
      default: s = 128;
    endcase
    return CW'(b + s);
  endfunction

  logic [15:0] pq_mem [QDEPTH];
  logic [13:0] sq_mem [QDEPTH];
  logic [AW-1:0] sq_wp, sq_rp, p_ptr, loop_ptr;
  logic [AW:0] sq_cnt;
  logic [PER_W-1:0] tb_cnt;
  logic [CW-1:0] conv_cnt;
  logic [OW-1:0] ovh_cnt;
  logic [7:0] cur_chan, num;
  logic [3:0] cur_tag;
  pst_t p_st;
  logic pend, late_run;

  logic unused_bits;
  assign unused_bits = ^{pq_wdata[31], pq_wdata[28:24], pq_wdata[17:16], pq_wdata[7:0],
                         sq_wdata[31:24], sq_wdata[17:16], sq_wdata[7:0]};

  logic [15:0] pcmd;
  logic [13:0] icmd;
  logic trig, conv_free, start, pri_issue, sec_issue, issue, stall, done, trig_bad, sq_push;

  assign pcmd      = pq_mem[p_ptr];
  assign trig      = trig_en && (tb_cnt == trig_period);
  assign conv_free = (conv_cnt == '0);
  assign start     = (p_st == P_WAIT) && (trig || pend) && conv_free;
  assign pri_issue = conv_free && (start || p_st == P_RUN);
  assign sec_issue = conv_free && (p_st == P_WAIT) && !trig && !pend && (sq_cnt != '0);
  assign issue     = pri_issue || sec_issue;
  assign icmd      = pri_issue ? pcmd[13:0] : sq_mem[sq_rp];
  assign stall     = res_valid && !res_ready;
  assign done      = (conv_cnt == CW'(1)) && !stall;
  assign trig_bad  = trig && (pend || (p_st != P_WAIT && !late_run));
  assign sq_push   = sq_we && (sq_cnt != (AW+1)'(QDEPTH));

  always_ff @(posedge clk) begin
    if (pq_we) pq_mem[pq_waddr] <= {pq_wdata[30:29], pq_wdata[23:18], pq_wdata[15:8]};
    if (sq_push) sq_mem[sq_wp] <= {sq_wdata[23:18], sq_wdata[15:8]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_wp <= '0; sq_rp <= '0; sq_cnt <= '0;
    end else begin
      if (sq_push) sq_wp <= sq_wp + 1'b1;
      if (sec_issue) sq_rp <= sq_rp + 1'b1;
      sq_cnt <= sq_cnt + (AW+1)'(sq_push) - (AW+1)'(sec_issue);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !trig_en || trig) tb_cnt <= '0;
    else tb_cnt <= tb_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) conv_cnt <= '0;
    else if (issue) conv_cnt <= conv_len(icmd) - CW'(1);
    else if (done) conv_cnt <= '0;
    else if (conv_cnt > CW'(1)) conv_cnt <= conv_cnt - CW'(1);
    if (issue) begin
      cur_chan <= icmd[7:0];
      cur_tag  <= icmd[13:10];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0; num <= '0; res_data <= '0; res_tag <= '0;
    end else if (done) begin
      res_valid <= 1'b1;
      res_data  <= {cur_chan, num};
      res_tag   <= cur_tag;
      num       <= num + 1'b1;
    end else if (res_ready) res_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p_st <= P_WAIT; p_ptr <= '0; loop_ptr <= '0; ovh_cnt <= '0;
      pend <= 1'b0; late_run <= 1'b0; ovf_flag <= 1'b0;
    end else begin
      if (start) late_run <= pend;
      if (pri_issue) begin
        if (pcmd[14]) loop_ptr <= p_ptr;
        if (pcmd[15]) begin
          p_ptr   <= pcmd[14] ? p_ptr : loop_ptr;
          p_st    <= P_OVH;
          ovh_cnt <= OW'(conv_len(pcmd[13:0])) + OW'(OVH_CLKS - 1);
        end else begin
          p_ptr <= p_ptr + 1'b1;
          p_st  <= P_RUN;
        end
      end else if (p_st == P_OVH) begin
        if (ovh_cnt <= OW'(1)) begin
          p_st <= P_WAIT; ovh_cnt <= '0;
        end else ovh_cnt <= ovh_cnt - OW'(1);
      end
      if (start) pend <= 1'b0;
      else if (trig && !trig_bad) pend <= 1'b1;
      if (trig_bad) ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
    end
  end
endmodule

module adc_seq_checks #(parameter int CW = 8) (
  input logic          clk,
  input logic          rst,
  input logic          trig_en,
  input logic          ovf_clr,
  input logic          ovf_flag,
  input logic          res_valid,
  input logic          res_ready,
  input logic [15:0]   res_data,
  input logic [3:0]    res_tag,
  input logic          pri_issue,
  input logic          sec_issue,
  input logic [CW-1:0] conv_cnt
);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !ovf_clr |=> ovf_flag);
  assert_ovf_from_trigger_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> $past(trig_en));
  assert_result_held_R11: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_tag));
  assert_single_issuer_R9: assert property (@(posedge clk) disable iff (rst)
    !(pri_issue && sec_issue));
  assert_min_conv_time_R2: assert property (@(posedge clk) disable iff (rst)
    (pri_issue || sec_issue) |=> (conv_cnt >= CW'(14)));
  assert_reset_state_R12: assert property (@(posedge clk)
    rst |=> !res_valid && !ovf_flag);
endmodule

bind adc_cmd_sequencer adc_seq_checks #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .trig_en(trig_en), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
  .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data), .res_tag(res_tag),
  .pri_issue(pri_issue), .sec_issue(sec_issue), .conv_cnt(conv_cnt)
);

// File: tb/sim_adc_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_adc_cmd_sequencer;
  logic clk = 1'b0, rst = 1'b1;
  logic pq_we = 0, sq_we = 0, trig_en = 0, ovf_clr = 0, res_ready = 1;
  logic [2:0] pq_waddr = 0;
  logic [31:0] pq_wdata = 0, sq_wdata = 0;
  logic [15:0] trig_period = 0;
  logic ovf_flag, res_valid;
  logic [15:0] res_data;
  logic [3:0] res_tag;

  adc_cmd_sequencer u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, nlog = 0, nsec = 0;
  int lg_tag [512];
  int lg_data [512];
  int lg_cyc [512];
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk)
    if (res_valid && res_ready && nlog < 512) begin
      lg_tag[nlog] = res_tag; lg_data[nlog] = res_data; lg_cyc[nlog] = cyc;
      if (res_tag == 4'd15) nsec = nsec + 1;
      nlog = nlog + 1;
    end

  function automatic logic [31:0] cw(bit pz, bit rp, int tag, int code, int ch);
    logic [31:0] w = '0;
    w[30] = pz; w[29] = rp; w[23:20] = tag[3:0]; w[19:18] = code[1:0]; w[15:8] = ch[7:0];
    return w;
  endfunction

  function automatic int ctime(int ch, int code);
    return ((ch >= 96 && ch <= 127) ? 13 : 14) + (code == 0 ? 2 : code == 1 ? 8 : code == 2 ? 64 : 128);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1; trig_en = 0; pq_we = 0; sq_we = 0; ovf_clr = 0; res_ready = 1;
    step(3);
    rst = 0; nlog = 0; nsec = 0;
  endtask

  task automatic wr_p(input int i, input logic [31:0] w);
    pq_we = 1; pq_waddr = i[2:0]; pq_wdata = w; step(1); pq_we = 0;
  endtask

  task automatic wr_s(input logic [31:0] w);
    sq_we = 1; sq_wdata = w; step(1); sq_we = 0;
  endtask

  task automatic wait_logs(input int n, input int lim);
    for (int i = 0; i < lim && nlog < n; i++) step(1);
  endtask

  task automatic load_main();
    int chs [8] = '{96, 97, 98, 96, 97, 6, 96, 97};
    for (int i = 0; i < 8; i++) wr_p(i, cw(i == 7, i == 0, i, 0, chs[i]));
  endtask

  task automatic t_reset();
    do_reset();
    step(2);
    chk("R12 valid after reset", res_valid, 0);
    chk("R12 overflow after reset", ovf_flag, 0);
  endtask

  task automatic t_stream();
    int ch [6] = '{96, 6, 100, 40, 127, 95};
    int cd [6] = '{0, 1, 2, 3, 0, 0};
    do_reset();
    for (int i = 0; i < 6; i++) begin
      logic [31:0] w = cw(i == 2, i == 3, i + 1, cd[i], ch[i]);
      if (i == 1) w = w | 32'h9F03_00FF;
      wr_s(w);
    end
    wait_logs(6, 2000);
    chk("R9 stream result count", nlog, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R9 R1 stream tag order", lg_tag[i], i + 1);
      chk("R3 R1 result data", lg_data[i], (ch[i] << 8) | i);
      if (i > 0) chk("R2 conversion spacing", lg_cyc[i] - lg_cyc[i-1], ctime(ch[i], cd[i]));
    end
  endtask

  task automatic t_hold();
    do_reset();
    res_ready = 0;
    wr_s(cw(0, 0, 3, 0, 96));
    wr_s(cw(0, 0, 4, 0, 97));
    step(40);
    chk("R11 result held valid", res_valid, 1);
    chk("R11 held data", res_data, (96 << 8) | 0);
    step(30);
    chk("R11 held tag", res_tag, 3);
    chk("R11 held data later", res_data, (96 << 8) | 0);
    res_ready = 1;
    wait_logs(2, 100);
    chk("R11 both results delivered", nlog, 2);
    chk("R11 second result", lg_data[1], (97 << 8) | 1);
  endtask

  task automatic t_loop();
    int exp [14] = '{0, 1, 2, 3, 4, 5, 2, 3, 4, 5, 2, 3, 4, 5};
    do_reset();
    for (int i = 0; i < 8; i++) wr_p(i, cw(i == 5, i == 2, i, 0, 96 + i));
    trig_period = 299; trig_en = 1;
    wait_logs(14, 2000);
    for (int i = 0; i < 14; i++) chk("R5 replay order", lg_tag[i], exp[i]);
    chk("R4 back to back issue", lg_cyc[1] - lg_cyc[0], 15);
    chk("R4 trigger period", lg_cyc[10] - lg_cyc[6], 300);
    do_reset();
    trig_period = 299; trig_en = 1;
    wait_logs(6, 1000);
    for (int i = 0; i < 6; i++) chk("R12 pointers cleared, contents kept", lg_tag[i], i);
    chk("R12 count restarts", lg_data[0] & 255, 0);
  endtask

  task automatic t_overhead();
    int a = -1, b = -1, sec = 0;
    do_reset();
    load_main();
    trig_period = 134; trig_en = 1;
    step(200);
    wr_s(cw(0, 0, 15, 0, 6));
    step(700);
    chk("R6 no overflow at run plus 14", ovf_flag, 0);
    for (int i = 0; i < nlog; i++) begin
      if (lg_tag[i] == 15) sec++;
      if (lg_tag[i] == 0) begin if (a < 0) a = i; else if (b < 0) b = i; end
    end
    chk("R9 no secondary in overhead", sec, 0);
    chk("R6 run period", (b >= 0) ? lg_cyc[b] - lg_cyc[a] : -1, 135);
    trig_en = 0;
    step(300);
    trig_period = 133; trig_en = 1;
    step(600);
    chk("R6 R7 overflow one clock short", ovf_flag, 1);
    trig_en = 0;
    step(50);
    chk("R8 flag sticky", ovf_flag, 1);
    ovf_clr = 1; step(1); ovf_clr = 0;
    step(1);
    chk("R8 cleared by write one", ovf_flag, 0);
  endtask

  task automatic t_slack(input int pm1, input int exp_runs);
    int s1 = -1, s2 = -1, runs = 0;
    do_reset();
    load_main();
    trig_period = pm1[15:0]; trig_en = 1;
    step(200);
    for (int i = 0; i < 3; i++) wr_s(cw(0, 0, 15, 0, 6));
    for (int i = 0; i < 20000 && nsec < 2; i++) step(1);
    for (int i = 0; i < nlog; i++)
      if (lg_tag[i] == 15) begin if (s1 < 0) s1 = i; else if (s2 < 0) s2 = i; end
      else if (lg_tag[i] == 0 && s1 >= 0 && s2 < 0) runs++;
    chk("R10 secondary results seen", nsec >= 2, 1);
    chk("R10 runs between secondaries", runs, exp_runs);
    chk("R10 no overflow while catching up", ovf_flag, 0);
  endtask

  initial begin
    t_reset();
    t_stream();
    t_hold();
    t_loop();
    t_overhead();
    t_slack(150, 1);
    t_slack(142, 2);
    t_slack(135, 16);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule